// File: doc/BRIEF.md
# Dual-Bank Memory Arbiter With Boot-Time Mapping

Two processor ports, core A and core B, reach two equal on-chip RAM banks through this block. A mapping mode is taken from the `mode_i` pin once after reset and then held. The mode decides which core reaches which bank. In the split mode each core owns one bank. In the joined mode core A sees both banks as one contiguous space and core B sees nothing. In the shared mode core A keeps bank 0 to itself and shares bank 1 with core B.

A bank with one owner accepts an access on every cycle. A shared bank gives its slot to each core in turn, one cycle each. A core that misses its slot keeps `req` high until it is acknowledged. When a request falls outside the space the mode gives that core, the block acknowledges it at once with an error flag and touches no bank. Read data comes out of a registered synchronous read one cycle after the acknowledge.

Both banks are inferred arrays. Their depth in 32-bit words is the parameter `BANK_WORDS`, and a full-size build sets it to 65536 (256 KB per bank). Addresses are word addresses of `$clog2(BANK_WORDS)+1` bits. The top bit selects the half of the port's space and the lower bits index words inside a bank.

Top module: `dual_bank_arbiter`

## Requirements
- R1: `mode_i` is sampled on the first rising clock edge after `rst_ni` is released. No request is acknowledged before that edge, and later changes of `mode_i` have no effect until the next reset.
- R2: Mode 0: core A with address top bit 0 reaches bank 0, and core B with top bit 0 reaches bank 1. A top bit of 1 on either core is an error.
- R3: Mode 1: core A's address top bit selects the bank (0 selects bank 0, 1 selects bank 1) and the lower bits index inside it. Every request from core B is an error.
- R4: Mode 2: core A with top bit 0 reaches bank 0 privately, and with top bit 1 reaches bank 1 as a shared bank. Core B with top bit 0 reaches shared bank 1, and with top bit 1 gets an error.
- R5: A request to a privately owned bank is acknowledged, without error, in the same cycle that `req` is high, on every cycle.
- R6: A slot toggle flips on every clock edge from reset release. It starts in core A's slot and goes to core B's slot after the first edge. A shared-bank request is acknowledged only in its own core's slot, and the other core never reaches that bank in the same cycle.
- R7: The data from a read acknowledged in one cycle appears on `rdata_o` in the next cycle. A write changes only the bytes whose byte-enable bit is set, where `be[i]` covers data bits `8*i+7 : 8*i`.
- R8: A request to an unmapped address is acknowledged in the same cycle with `err_o` high, and neither bank is read or written.
- R9: Mode value 3 behaves exactly as mode 0.
- R10: `ack_o` and `err_o` are low on any cycle in which that port's `req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mapping mode, sampled once after reset |
| a_req_i | input | 1 | Core A request |
| a_we_i | input | 1 | Core A write enable |
| a_addr_i | input | AW | Core A word address |
| a_wdata_i | input | DW | Core A write data |
| a_be_i | input | DW/8 | Core A byte enables |
| a_ack_o | output | 1 | Core A acknowledge |
| a_err_o | output | 1 | Core A unmapped-address flag, valid with ack |
| a_rdata_o | output | DW | Core A read data, valid the cycle after a read ack |
| b_req_i | input | 1 | Core B request |
| b_we_i | input | 1 | Core B write enable |
| b_addr_i | input | AW | Core B word address |
| b_wdata_i | input | DW | Core B write data |
| b_be_i | input | DW/8 | Core B byte enables |
| b_ack_o | output | 1 | Core B acknowledge |
| b_err_o | output | 1 | Core B unmapped-address flag, valid with ack |
| b_rdata_o | output | DW | Core B read data, valid the cycle after a read ack |

## Verification
The bench builds the block with `BANK_WORDS` = 16. The address is then five bits wide, so random traffic hits the top bit and the unmapped halves often. Every word of both banks gets written in an opening sweep and is read back many times within a few hundred cycles. The bench resets the block in each of the four mode values, with mode 2 run twice. After each sampling edge it changes `mode_i` at random, so a wrongly latched mode shows up as a mismatch in the mapping or in the slot parity.

// File: rtl/dba_pkg.sv
package dba_pkg;
  typedef enum logic [1:0] {
    MAP_SPLIT = 2'd0,
    MAP_JOIN  = 2'd1,
    MAP_SHARE = 2'd2,
    MAP_RSVD  = 2'd3
  } map_e;
endpackage

// File: rtl/dba_cfg.sv
module dba_cfg
  import dba_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  output map_e       map_o,
  output logic       live_o,
  output logic       turn_o
);
  map_e map_q;
  logic live_q, turn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q  <= MAP_SPLIT;
      live_q <= 1'b0;
      turn_q <= 1'b0;
    end else begin
      turn_q <= ~turn_q;
      if (!live_q) begin
        live_q <= 1'b1;
        // reserved code folds onto split mapping
        map_q  <= (mode_i == MAP_RSVD) ? MAP_SPLIT : map_e'(mode_i);
      end
    end
  end

  assign map_o  = map_q;
  assign live_o = live_q;
  assign turn_o = turn_q;

  a_r1_map_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |=> $stable(map_q));
  a_r6_turn_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (turn_q != $past(turn_q)));
  a_r9_no_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (map_q != MAP_RSVD));
endmodule

// File: rtl/dba_route.sv
module dba_route
  import dba_pkg::*;
#(
  parameter int PORT = 0
) (
  input  map_e map_i,
  input  logic top_i,
  output logic ok_o,
  output logic bank_o,
  output logic shared_o
);
  always_comb begin
    ok_o     = 1'b0;
    bank_o   = 1'b0;
    shared_o = 1'b0;
    unique case (map_i)
      MAP_JOIN: begin
        if (PORT == 0) begin
          ok_o   = 1'b1;
          bank_o = top_i;
        end
      end
      MAP_SHARE: begin
        if (PORT == 0) begin
          ok_o     = 1'b1;
          bank_o   = top_i;
          shared_o = top_i;
        end else begin
          ok_o     = !top_i;
          bank_o   = 1'b1;
          shared_o = 1'b1;
        end
      end
      default: begin
        ok_o   = !top_i;
        bank_o = (PORT == 1);
      end
    endcase
  end
endmodule

// File: rtl/dba_bank.sv
module dba_bank #(
  parameter int WORDS = 1024,
  parameter int DW    = 32,
  localparam int IW   = $clog2(WORDS),
  localparam int BW   = DW / 8
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [BW-1:0] be_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [WORDS];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) begin
        for (int i = 0; i < BW; i++)
          if (be_i[i]) mem_q[idx_i][8*i +: 8] <= wdata_i[8*i +: 8];
      end else begin
        rd_q <= mem_q[idx_i];
      end
    end
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/dual_bank_arbiter.sv
module dual_bank_arbiter
  import dba_pkg::*;
#(
  parameter int BANK_WORDS = 1024,
  parameter int DW         = 32,
  localparam int IW        = $clog2(BANK_WORDS),
  localparam int AW        = IW + 1,
  localparam int BW        = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          a_req_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  input  logic [BW-1:0] a_be_i,
  output logic          a_ack_o,
  output logic          a_err_o,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_req_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  input  logic [BW-1:0] b_be_i,
  output logic          b_ack_o,
  output logic          b_err_o,
  output logic [DW-1:0] b_rdata_o
);
  map_e map;
  logic live, turn;

  dba_cfg u_cfg (
    .clk_i (clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .map_o (map),   .live_o(live),   .turn_o(turn)
  );

  logic [1:0]          req, we, ok, bsel, shr, gnt, eack, ack;
  logic [1:0][AW-1:0]  addr;
  logic [1:0][DW-1:0]  wdata, rdata;
  logic [1:0][BW-1:0]  be;
  logic [1:0][DW-1:0]  bank_rd;
  logic [1:0][1:0]     use_pb;   // [bank][port]
  logic [1:0]          sel_q;

  assign req   = {b_req_i, a_req_i};
  assign we    = {b_we_i, a_we_i};
  assign addr  = {b_addr_i, a_addr_i};
  assign wdata = {b_wdata_i, a_wdata_i};
  assign be    = {b_be_i, a_be_i};

  for (genvar p = 0; p < 2; p++) begin : g_port
    dba_route #(.PORT(p)) u_route (
      .map_i(map), .top_i(addr[p][AW-1]),
      .ok_o(ok[p]), .bank_o(bsel[p]), .shared_o(shr[p])
    );

    // shared bank: port 0 owns even slot, port 1 odd slot
    assign gnt[p]  = req[p] && live && ok[p] && (!shr[p] || (turn == (p == 1)));
    assign eack[p] = req[p] && live && !ok[p];
    assign ack[p]  = gnt[p] || eack[p];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                sel_q[p] <= 1'b0;
      else if (gnt[p] && !we[p])  sel_q[p] <= bsel[p];
    end
    assign rdata[p] = bank_rd[sel_q[p]];

    a_r10_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req[p] |-> !ack[p]);
    a_r8_err_no_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eack[p] |-> !use_pb[0][p] && !use_pb[1][p]);
    a_r5_private_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live && req[p] && ok[p] && !shr[p]) |-> gnt[p]);
  end

  for (genvar k = 0; k < 2; k++) begin : g_bank
    logic          en;
    logic          pick_b;
    logic [IW-1:0] idx;

    assign use_pb[k][0] = gnt[0] && (bsel[0] == (k == 1));
    assign use_pb[k][1] = gnt[1] && (bsel[1] == (k == 1));
    assign en     = |use_pb[k];
    assign pick_b = use_pb[k][1];
    assign idx    = addr[pick_b][IW-1:0];

    dba_bank #(.WORDS(BANK_WORDS), .DW(DW)) u_bank (
      .clk_i  (clk_i),
      .en_i   (en),
      .we_i   (we[pick_b]),
      .be_i   (be[pick_b]),
      .idx_i  (idx),
      .wdata_i(wdata[pick_b]),
      .rdata_o(bank_rd[k])
    );

    a_r6_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(use_pb[k][0] && use_pb[k][1]));
  end

  assign a_ack_o   = ack[0];
  assign a_err_o   = eack[0];
  assign a_rdata_o = rdata[0];
  assign b_ack_o   = ack[1];
  assign b_err_o   = eack[1];
  assign b_rdata_o = rdata[1];

  a_r3_b_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map == MAP_JOIN && b_ack_o) |-> b_err_o);
  a_r1_quiet_before_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live |-> !a_ack_o && !b_ack_o);
endmodule

// File: tb/dual_bank_arbiter_tb.sv
`timescale 1ns/1ps
module dual_bank_arbiter_tb;
  localparam int BANK_WORDS = 16;
  localparam int IW = $clog2(BANK_WORDS);
  localparam int AW = IW + 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [1:0]    mode;
  logic          req_d [2];
  logic          we_d  [2];
  logic [AW-1:0] addr_d[2];
  logic [31:0]   wd_d  [2];
  logic [3:0]    be_d  [2];
  logic          ack   [2];
  logic          err   [2];
  logic [31:0]   rd    [2];

  dual_bank_arbiter #(.BANK_WORDS(BANK_WORDS), .DW(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .a_req_i(req_d[0]), .a_we_i(we_d[0]), .a_addr_i(addr_d[0]), .a_wdata_i(wd_d[0]),
    .a_be_i(be_d[0]), .a_ack_o(ack[0]), .a_err_o(err[0]), .a_rdata_o(rd[0]),
    .b_req_i(req_d[1]), .b_we_i(we_d[1]), .b_addr_i(addr_d[1]), .b_wdata_i(wd_d[1]),
    .b_be_i(be_d[1]), .b_ack_o(ack[1]), .b_err_o(err[1]), .b_rdata_o(rd[1])
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [2][BANK_WORDS];
  bit          live_m, turn_m, in_rst;
  int          mode_m;
  bit          rd_pend[2];
  logic [31:0] rd_exp [2];

  task automatic chk(bit good, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // spec of the mapping, per requirement text
  task automatic route(int p, int m, logic top, output bit ok, output int bank, output bit shr);
    int mm = (m == 3) ? 0 : m;
    ok = 0; bank = 0; shr = 0;
    if (mm == 0) begin ok = !top; bank = p; end
    else if (mm == 1) begin if (p == 0) begin ok = 1; bank = top; end end
    else begin
      if (p == 0) begin ok = 1; bank = top; shr = top; end
      else begin ok = !top; bank = 1; shr = 1; end
    end
  endtask

  function automatic string mtag(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R9";
    endcase
  endfunction

  // called just after a negedge with inputs already set
  task automatic tick();
    bit ok[2], shr[2], gnt[2], ea[2];
    int bank[2];
    string tg;
    #1;
    for (int p = 0; p < 2; p++) begin
      route(p, mode_m, addr_d[p][AW-1], ok[p], bank[p], shr[p]);
      gnt[p] = req_d[p] && live_m && ok[p] && (!shr[p] || (turn_m == (p == 1)));
      ea[p]  = req_d[p] && live_m && !ok[p];
      if (!live_m) tg = "R1";
      else if (!req_d[p]) tg = "R10";
      else if (!ok[p]) tg = "R8";
      else if (shr[p]) tg = "R6";
      else tg = "R5";
      tg = {tg, "/", mtag(mode_m), p ? "/B" : "/A"};
      chk(ack[p] === (gnt[p] || ea[p]), {tg, " ack"}, 32'(ack[p]), 32'(gnt[p] || ea[p]));
      chk(err[p] === ea[p], {tg, " err"}, 32'(err[p]), 32'(ea[p]));
      if (rd_pend[p])
        chk(rd[p] === rd_exp[p], {"R7/", mtag(mode_m), " rdata"}, rd[p], rd_exp[p]);
    end
    @(posedge clk);
    for (int p = 0; p < 2; p++) begin
      rd_pend[p] = 0;
      if (gnt[p] && !we_d[p]) begin
        rd_pend[p] = 1;
        rd_exp[p]  = mem[bank[p]][addr_d[p][IW-1:0]];
      end
    end
    for (int p = 0; p < 2; p++)
      if (gnt[p] && we_d[p])
        for (int i = 0; i < 4; i++)
          if (be_d[p][i]) mem[bank[p]][addr_d[p][IW-1:0]][8*i +: 8] = wd_d[p][8*i +: 8];
    if (in_rst) begin
      live_m = 0; turn_m = 0;
    end else begin
      turn_m = !turn_m;
      if (!live_m) begin live_m = 1; mode_m = mode; end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    for (int p = 0; p < 2; p++) begin
      req_d[p] = 0; we_d[p] = 0; addr_d[p] = '0; wd_d[p] = '0; be_d[p] = '0;
    end
  endtask

  task automatic rnd_port(int p);
    req_d[p]  = ($urandom_range(3) != 0);
    we_d[p]   = $urandom_range(1);
    addr_d[p] = AW'($urandom);
    wd_d[p]   = $urandom;
    be_d[p]   = 4'($urandom);
  endtask

  task automatic phase(int m, int n);
    idle(); mode = 2'(m); rst_n = 0; in_rst = 1;
    for (int p = 0; p < 2; p++) rd_pend[p] = 0;
    repeat (3) tick();
    rst_n = 1; in_rst = 0;
    // sampling cycle: requests present but must not be acked (R1)
    req_d[0] = 1; req_d[1] = 1;
    tick();
    mode = 2'($urandom);
    if (m == 1) begin
      for (int a = 0; a < 2 * BANK_WORDS; a++) begin
        idle(); req_d[0] = 1; we_d[0] = 1; addr_d[0] = AW'(a);
        wd_d[0] = $urandom; be_d[0] = 4'hF;
        tick();
      end
    end
    for (int c = 0; c < n; c++) begin
      rnd_port(0); rnd_port(1);
      if (c % 7 == 0) mode = 2'($urandom);
      tick();
    end
  endtask

  initial begin
    rst_n = 0; mode = 0; in_rst = 1; live_m = 0; turn_m = 0; mode_m = 0;
    idle();
    @(negedge clk);
    phase(1, 400);
    phase(0, 400);
    phase(2, 500);
    phase(3, 300);
    phase(2, 300);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule